// File: doc/BRIEF.md
# ALU with Condition Flags

This block is a 64-bit integer arithmetic/logic unit. It pairs a three-flag condition register (zero, sign, overflow) with a condition evaluator. The unit takes two register operands and a function code, and it returns the result in the same cycle. When the flag-load enable is high and the function code is one of the four defined operations, the unit captures the zero, sign and overflow flags of that result at the next rising clock edge. No other input changes the flags.

A separate 4-bit condition selector reads the stored flags and drives one condition-true bit. The surrounding datapath uses this one bit for two jobs: it decides whether a jump is taken, and it decides whether a conditional move writes its destination. Jumps use selector values 0 to 6. Conditional moves use selector values 1 to 6.

The interface is plain control and data. There is no stream and no handshake, so back-pressure does not arise. Every input is sampled combinationally or at the clock edge.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 (add) gives `result = opnd_b + opnd_a` modulo 2^64.
- R2: Function code 1 (subtract) gives `result = opnd_b - opnd_a` modulo 2^64.
- R3: Function code 2 gives the bitwise AND of the operands. Function code 3 gives the bitwise XOR.
- R4: When `set_cc` is 1 and the function code is 0..3, the flags load at the rising clock edge: zf is 1 when the result is zero, and sf is result bit 63. The new flags are visible on the outputs after that edge.
- R5: of is set on signed overflow. For add, the operands share a sign and the result sign differs. For subtract, the operand signs differ and the result sign differs from opnd_b. For AND and XOR, of is loaded as 0.
- R6: Function codes 4..15 give a zero result and never load the flags. When `set_cc` is 0, the flags hold.
- R7: While `rst_n` is 0, the flags are zf=1, sf=0, of=0.
- R8: cond_sel 0 (always) is true. The other codes read the stored flags as follows:
  - 1: le = (sf^of)|zf
  - 2: l = sf^of
  - 3: e = zf
  - 4: ne = ~zf
  - 5: ge = ~(sf^of)
  - 6: g = ~(sf^of)&~zf
- R9: cond_sel 7..15 gives cond_true = 0.
- R10: cond_true depends only on the stored flags. In the cycle in which a flag-setting operation is presented, cond_true still reflects the previous flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| opnd_a | input | 64 | Operand A (the subtrahend for subtract) |
| opnd_b | input | 64 | Operand B |
| fn | input | 4 | Function code: 0 add, 1 sub, 2 and, 3 xor |
| set_cc | input | 1 | Load the flags from this operation |
| cond_sel | input | 4 | Condition selector, codes 0..6 |
| result | output | 64 | Combinational result |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored sign flag |
| of | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Selected condition holds on the stored flags |

## Verification
The bench applies all four operations to every pair of operands from a set of sign-boundary values, including 0, 1, all-ones, the most positive value and the most negative value. This catches an overflow rule keyed to the wrong operand, or a subtract with its operands swapped. Either fault shows up as a wrong `of` after min-minus-one or max-plus-one.

It then drives the flags into each of the six reachable (zf, sf, of) combinations and sweeps all 16 selectors. A mistake in the signed-less rule would be visible when sf and of are both set, where a design using sf alone reports "less" wrongly.

Undefined function codes and `set_cc=0` are checked for unchanged flags, so a design that loads flags on any function code fails. The cycle of presentation is checked so that a design computing cond_true from the live result fails.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int unsigned FN_W  = 4;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [FN_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_XOR = 4'd3
  } alu_op_e;

  typedef enum logic [SEL_W-1:0] {
    C_ALWAYS = 4'd0,
    C_LE     = 4'd1,
    C_LT     = 4'd2,
    C_EQ     = 4'd3,
    C_NE     = 4'd4,
    C_GE     = 4'd5,
    C_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    y,
  output flags_t          nxt,
  output logic            fn_ok
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum, diff;
  logic         add_ov, sub_ov;

  assign sum    = b + a;
  assign diff   = b - a;
  assign add_ov = (a[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
  assign sub_ov = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);

  always_comb begin
    fn_ok  = 1'b1;
    y      = '0;
    nxt.of = 1'b0;
    unique case (fn)
      OP_ADD:  begin y = sum;   nxt.of = add_ov; end
      OP_SUB:  begin y = diff;  nxt.of = sub_ov; end
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      default: fn_ok = 1'b0;
    endcase
    nxt.zf = (y == '0);
    nxt.sf = y[MSB];
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= FLAGS_RST;
    else if (load) q <= d;
  end

  // R7: after a reset cycle the stored flags read zf=1, sf=0, of=0
  a_r7_reset_val: assert property (@(posedge clk)
    !rst_n |=> (q == FLAGS_RST));

  // R6: without a load the register holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cc_pkg::*;
(
  input  flags_t           f,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic lt;
  assign lt = f.sf ^ f.of;

  always_comb begin
    unique case (sel)
      C_ALWAYS: hit = 1'b1;
      C_LE:     hit = lt | f.zf;
      C_LT:     hit = lt;
      C_EQ:     hit = f.zf;
      C_NE:     hit = ~f.zf;
      C_GE:     hit = ~lt;
      C_GT:     hit = ~lt & ~f.zf;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDTH-1:0]    opnd_a,
  input  logic [WIDTH-1:0]    opnd_b,
  input  logic [FN_W-1:0]     fn,
  input  logic                set_cc,
  input  logic [SEL_W-1:0]    cond_sel,
  output logic [WIDTH-1:0]    result,
  output logic                zf,
  output logic                sf,
  output logic                of,
  output logic                cond_true
);
  flags_t nxt_flags, cur_flags;
  logic   fn_ok;

  alu_datapath #(.W(WIDTH)) u_dp (
    .a(opnd_a), .b(opnd_b), .fn(fn),
    .y(result), .nxt(nxt_flags), .fn_ok(fn_ok)
  );

  flag_store u_flags (
    .clk(clk), .rst_n(rst_n), .load(set_cc && fn_ok),
    .d(nxt_flags), .q(cur_flags)
  );

  cond_eval u_cond (
    .f(cur_flags), .sel(cond_sel), .hit(cond_true)
  );

  assign zf = cur_flags.zf;
  assign sf = cur_flags.sf;
  assign of = cur_flags.of;

  // R6: undefined function codes never touch the flags
  a_r6_bad_fn: assert property (@(posedge clk) disable iff (!rst_n)
    (fn > 4'd3) |=> $stable({zf, sf, of}));
  a_r6_bad_fn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fn > 4'd3) |-> (result == '0));
  // R4: zero and sign follow the presented result
  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cc && fn <= 4'd3) |=> (zf == ($past(result) == '0)));
  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cc && fn <= 4'd3) |=> (sf == $past(result[WIDTH-1])));
  // R5: logical operations clear overflow
  a_r5_logic_of: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cc && (fn == 4'd2 || fn == 4'd3)) |=> !of);
  // R8 / R9: fixed selector outcomes
  a_r8_always: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd0) |-> cond_true);
  a_r8_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd3) |-> (cond_true == zf));
  a_r9_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel > 4'd6) |-> !cond_true);
endmodule

// File: tb/alu_cc_unit_tb.sv
`timescale 1ns/1ps
module alu_cc_unit_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]   fn = '0, cond_sel = '0;
  logic         set_cc = 1'b0;
  logic [W-1:0] result;
  logic         zf, sf, of, cond_true;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic mz, ms, mo;  // model of stored flags

  always #10 clk = ~clk;

  alu_cc_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .fn(fn), .set_cc(set_cc), .cond_sel(cond_sel), .result(result),
    .zf(zf), .sf(sf), .of(of), .cond_true(cond_true)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W+2:0] model(input logic [W-1:0] a, b,
                                         input logic [3:0] f);
    logic [W-1:0] r; logic o;
    o = 1'b0;
    case (f)
      4'd0: begin r = b + a; o = (a[W-1] == b[W-1]) && (r[W-1] != b[W-1]); end
      4'd1: begin r = b - a; o = (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]); end
      4'd2: r = a & b;
      4'd3: r = a ^ b;
      default: r = '0;
    endcase
    return {r, (r == '0), r[W-1], o};
  endfunction

  function automatic logic exp_cond(input logic [3:0] s, input logic z, sg, o);
    case (s)
      4'd0: return 1'b1;
      4'd1: return (sg ^ o) | z;
      4'd2: return sg ^ o;
      4'd3: return z;
      4'd4: return ~z;
      4'd5: return ~(sg ^ o);
      4'd6: return ~(sg ^ o) & ~z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, b, input logic [3:0] f,
                       input logic ld, input string req);
    logic [W+2:0] m;
    m = model(a, b, f);
    @(negedge clk);
    opnd_a = a; opnd_b = b; fn = f; set_cc = ld; cond_sel = 4'd3;
    #1;
    chk(result == m[W+2:3], req, result, m[W+2:3]);
    // R10: condition still reflects the previous flags
    chk(cond_true == mz, "R10 cond before edge", W'(cond_true), W'(mz));
    if (ld && f <= 4'd3) begin mz = m[2]; ms = m[1]; mo = m[0]; end
    @(negedge clk);
    set_cc = 1'b0;
    chk({zf, sf, of} == {mz, ms, mo},
        (f > 4'd3) ? "R6 bad fn flags" : (ld ? "R4/R5 flags" : "R6 hold flags"),
        W'({zf, sf, of}), W'({mz, ms, mo}));
  endtask

  task automatic sweep_cond();
    for (int s = 0; s < 16; s++) begin
      cond_sel = 4'(s);
      #1;
      chk(cond_true == exp_cond(4'(s), mz, ms, mo),
          (s > 6) ? "R9 undefined selector" : "R8 condition",
          W'(cond_true), W'(exp_cond(4'(s), mz, ms, mo)));
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] vals [8];
    logic [W-1:0] MAXP, MINN;
    MAXP = {1'b0, {(W-1){1'b1}}};
    MINN = {1'b1, {(W-1){1'b0}}};
    vals[0] = '0;            vals[1] = W'(1);
    vals[2] = '1;            vals[3] = MAXP;
    vals[4] = MINN;          vals[5] = {(W/2){2'b01}};
    vals[6] = {(W/2){2'b10}}; vals[7] = W'(64'h0123_4567_89AB_CDEF);
    mz = 1'b1; ms = 1'b0; mo = 1'b0;

    repeat (3) @(negedge clk);
    // R7: reset flags
    chk({zf, sf, of} == 3'b100, "R7 reset flags", W'({zf, sf, of}), W'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk({zf, sf, of} == 3'b100, "R7 flags after release", W'({zf, sf, of}), W'(3'b100));
    sweep_cond();

    // R1 R2 R3 R4 R5: all pairs, all defined operations
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(vals[i], vals[j], 4'(f), 1'b1,
                (f == 0) ? "R1 add" : (f == 1) ? "R2 sub" : "R3 logic");

    // R6: undefined codes and no-load
    apply(W'(1), W'(1), 4'd0, 1'b1, "R1 add");
    for (int f = 4; f < 16; f++) apply(MINN, MINN, 4'(f), 1'b1, "R6 bad fn result");
    apply('0, '0, 4'd0, 1'b0, "R6 hold result");
    apply(MAXP, W'(1), 4'd0, 1'b0, "R6 hold result");

    // R8 R9: six reachable flag combinations
    apply(W'(1), W'(1), 4'd0, 1'b1, "R8 set 000"); sweep_cond();
    apply('0, '0, 4'd0, 1'b1, "R8 set 100");       sweep_cond();
    apply('0, '1, 4'd0, 1'b1, "R8 set 010");       sweep_cond();
    apply(W'(1), MAXP, 4'd0, 1'b1, "R8 set 011");  sweep_cond();
    apply(W'(1), MINN, 4'd1, 1'b1, "R8 set 001");  sweep_cond();
    apply(MINN, MINN, 4'd0, 1'b1, "R8 set 101");   sweep_cond();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule